// File: doc/BRIEF.md
# Legacy DMA Channel Register File

This block is the host-facing register store for a four-channel legacy DMA controller. Software reaches it through a small 8-bit I/O port bus with a 4-bit port address, write data, a write strobe, a read strobe and combinational read data. Each channel keeps a 16-bit address and a 16-bit transfer count. Each of these is reached through one 8-bit port. A single byte-pointer flip-flop, shared by every channel, picks the low or the high half on each access.

The block also keeps a mask bit and a six-bit mode field per channel, a command byte, software request bits and terminal-count flags. A transfer engine outside this block reads the mask, mode, current address and current count from the output vectors. It returns new address and count values through an update strobe. When a count wraps past zero, the channel either reloads from its base copies or masks itself. Which one happens depends on its auto-initialise mode bit.

Top module: `dma_regfile`

## Requirements
- R1: Port 2n holds channel n's address and port 2n+1 holds its count, for n = 0..3. Every read or write strobe to ports 0..7 handles the byte picked by the shared pointer (0 = low byte, 1 = high byte) and then inverts the pointer.
- R2: A write to port 12 returns the pointer to the low byte, whatever the data.
- R3: A byte write updates that byte of the base copy. The current copy then becomes equal to the new base value. Reads of ports 0..7 return bytes of the current copy.
- R4: A write to port 10 uses data bits 1:0 as the channel. Data bit 2 = 1 sets that channel's mask bit and bit 2 = 0 clears it. Mask bit n appears on ch_mask[n].
- R5: A write to port 14 clears all four mask bits. A write to port 15 loads mask bit n from data bit n.
- R6: A write to port 11 uses data bits 1:0 as the channel and stores data bits 7:2 as that channel's mode, shown on ch_mode[6n+5:6n]. Data bit 4 (mode bit 2) is auto-initialise.
- R7: Hardware reset, and any write to port 13, set every mask bit. They also return the pointer to low and clear the command byte, the request bits and the terminal-count flags. Hardware reset also zeroes the addresses, counts and modes.
- R8: An eng_upd strobe for channel eng_ch copies eng_addr and eng_cnt into that channel's current address and count, unless R10's reload applies.
- R9: An update whose eng_cnt is all ones sets terminal-count flag n. Port 8 reads {request[3:0], tc[3:0]}. A read strobe on port 8 clears the flags in the next cycle. A flag set in that same cycle survives.
- R10: On terminal count with auto-initialise set, the current address and count reload from the base copies. Without auto-initialise, the engine values are taken and the channel's mask bit is set.
- R11: A write to port 8 stores the data byte on cmd_reg. A write to port 9 uses data bits 1:0 as the channel and data bit 2 as the request bit for it. Other ports read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_rdata | output | 8 | Read data for io_addr |
| eng_upd | input | 1 | Update strobe from the transfer engine |
| eng_ch | input | 2 | Channel being updated |
| eng_addr | input | 16 | New current address |
| eng_cnt | input | 16 | New current count |
| ch_mask | output | 4 | Per-channel mask bits |
| ch_mode | output | 24 | Per-channel six-bit mode fields |
| ch_addr | output | 64 | Per-channel current address |
| ch_cnt | output | 64 | Per-channel current count |
| cmd_reg | output | 8 | Command byte |

## Verification
The bench builds the block with its default of four channels and 16-bit registers. At that size all sixteen port addresses are decoded, so random traffic reaches every port. This includes the all-ones count that triggers terminal count, on channels with and without auto-initialise. These updates arrive in the same cycles as host writes and status reads, so collisions between the engine path and the host path occur often. The bench compares these collisions against its own behavioural model.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int AW     = 4;
  localparam int MODE_W = BYTE_W - 2;

  typedef enum logic [AW-1:0] {
    PORT_STAT   = 4'd8,
    PORT_REQ    = 4'd9,
    PORT_MASK1  = 4'd10,
    PORT_MODE   = 4'd11,
    PORT_CLRPTR = 4'd12,
    PORT_MRST   = 4'd13,
    PORT_CLRMSK = 4'd14,
    PORT_WRMSK  = 4'd15
  } ctl_port_e;

  // replace one byte of a register, chosen by the pointer
  function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] v,
                                                input logic hi,
                                                input logic [BYTE_W-1:0] b);
    return hi ? {b, v[BYTE_W-1:0]} : {v[REG_W-1:BYTE_W], b};
  endfunction

  function automatic logic [BYTE_W-1:0] get_byte(input logic [REG_W-1:0] v,
                                                 input logic hi);
    return hi ? v[REG_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  // count wrapped past zero
  function automatic logic is_wrap(input logic [REG_W-1:0] cnt);
    return &cnt;
  endfunction

endpackage

// File: rtl/dma_rf_byteptr.sv
module dma_rf_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic ptr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ptr_q <= 1'b0;
    else if (clr)   ptr_q <= 1'b0;
    else if (step)  ptr_q <= ~ptr_q;
  end
endmodule

// File: rtl/dma_rf_channel.sv
module dma_rf_channel
  import dma_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_a,
  input  logic              host_wr_c,
  input  logic              hi,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_d,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic              mask_ld,
  input  logic              mask_ld_val,
  input  logic              eng_we,
  input  logic [REG_W-1:0]  eng_a,
  input  logic [REG_W-1:0]  eng_c,
  output logic [REG_W-1:0]  cur_a,
  output logic [REG_W-1:0]  cur_c,
  output logic [MODE_W-1:0] mode_q,
  output logic              mask_q,
  output logic              tc_evt,
  output logic              autoinit
);
  logic [REG_W-1:0] base_a, base_c;
  logic [REG_W-1:0] nb_a, nb_c;

  assign autoinit = mode_q[2];
  assign tc_evt   = eng_we & is_wrap(eng_c);
  assign nb_a     = put_byte(base_a, hi, wbyte);
  assign nb_c     = put_byte(base_c, hi, wbyte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a <= '0;
      base_c <= '0;
      cur_a  <= '0;
      cur_c  <= '0;
      mode_q <= '0;
      mask_q <= 1'b1;
    end else begin
      if (eng_we) begin
        if (tc_evt && autoinit) begin
          cur_a <= base_a;
          cur_c <= base_c;
        end else begin
          cur_a <= eng_a;
          cur_c <= eng_c;
        end
      end
      if (host_wr_a) begin
        base_a <= nb_a;
        cur_a  <= nb_a;
      end
      if (host_wr_c) begin
        base_c <= nb_c;
        cur_c  <= nb_c;
      end
      if (mode_we) mode_q <= mode_d;
      if (tc_evt && !autoinit) mask_q <= 1'b1;
      if (mask_set)            mask_q <= 1'b1;
      else if (mask_clr)       mask_q <= 1'b0;
      else if (mask_ld)        mask_q <= mask_ld_val;
    end
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            io_addr,
  input  logic [BYTE_W-1:0]        io_wdata,
  input  logic                     io_wr,
  input  logic                     io_rd,
  output logic [BYTE_W-1:0]        io_rdata,
  input  logic                     eng_upd,
  input  logic [CH_W-1:0]          eng_ch,
  input  logic [REG_W-1:0]         eng_addr,
  input  logic [REG_W-1:0]         eng_cnt,
  output logic [NUM_CH-1:0]        ch_mask,
  output logic [NUM_CH*MODE_W-1:0] ch_mode,
  output logic [NUM_CH*REG_W-1:0]  ch_addr,
  output logic [NUM_CH*REG_W-1:0]  ch_cnt,
  output logic [BYTE_W-1:0]        cmd_reg
);
  // named events, also observed by the bound checker
  logic              ev_data_acc, ev_data_wr, ev_clrff, ev_mreset;
  logic              ev_clrall, ev_wrall, ev_mask1, ev_mode, ev_req;
  logic              ev_cmd, ev_stat_rd, ev_maskcmd;
  logic [NUM_CH-1:0] ev_tc, autoinit_v;
  logic [CH_W-1:0]   sel_ch, wsel;
  logic              is_cnt, ptr_q;
  logic [NUM_CH-1:0] tc_q, req_q;
  logic [REG_W-1:0]  cur_a [NUM_CH];
  logic [REG_W-1:0]  cur_c [NUM_CH];

  assign sel_ch      = io_addr[CH_W:1];
  assign is_cnt      = io_addr[0];
  assign wsel        = io_wdata[CH_W-1:0];
  assign ev_data_acc = (io_wr | io_rd) & ~io_addr[AW-1];
  assign ev_data_wr  = io_wr & ~io_addr[AW-1];
  assign ev_cmd      = io_wr && io_addr == PORT_STAT;
  assign ev_req      = io_wr && io_addr == PORT_REQ;
  assign ev_mask1    = io_wr && io_addr == PORT_MASK1;
  assign ev_mode     = io_wr && io_addr == PORT_MODE;
  assign ev_clrff    = io_wr && io_addr == PORT_CLRPTR;
  assign ev_mreset   = io_wr && io_addr == PORT_MRST;
  assign ev_clrall   = io_wr && io_addr == PORT_CLRMSK;
  assign ev_wrall    = io_wr && io_addr == PORT_WRMSK;
  assign ev_stat_rd  = io_rd && io_addr == PORT_STAT;
  assign ev_maskcmd  = ev_mask1 | ev_clrall | ev_wrall | ev_mreset;

  dma_rf_byteptr u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_clrff | ev_mreset),
    .step  (ev_data_acc),
    .ptr_q (ptr_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel_me, wsel_me;
    assign sel_me  = sel_ch == CH_W'(i);
    assign wsel_me = wsel == CH_W'(i);

    dma_rf_channel u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr_a   (ev_data_wr & sel_me & ~is_cnt),
      .host_wr_c   (ev_data_wr & sel_me & is_cnt),
      .hi          (ptr_q),
      .wbyte       (io_wdata),
      .mode_we     (ev_mode & wsel_me),
      .mode_d      (io_wdata[BYTE_W-1:2]),
      .mask_set    ((ev_mask1 & wsel_me & io_wdata[2]) | ev_mreset),
      .mask_clr    ((ev_mask1 & wsel_me & ~io_wdata[2]) | ev_clrall),
      .mask_ld     (ev_wrall),
      .mask_ld_val (io_wdata[i]),
      .eng_we      (eng_upd && eng_ch == CH_W'(i)),
      .eng_a       (eng_addr),
      .eng_c       (eng_cnt),
      .cur_a       (cur_a[i]),
      .cur_c       (cur_c[i]),
      .mode_q      (ch_mode[i*MODE_W +: MODE_W]),
      .mask_q      (ch_mask[i]),
      .tc_evt      (ev_tc[i]),
      .autoinit    (autoinit_v[i])
    );

    assign ch_addr[i*REG_W +: REG_W] = cur_a[i];
    assign ch_cnt[i*REG_W +: REG_W]  = cur_c[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ev_mreset) begin
      tc_q    <= '0;
      req_q   <= '0;
      cmd_reg <= '0;
    end else begin
      tc_q <= (ev_stat_rd ? '0 : tc_q) | ev_tc;
      if (ev_req)  req_q[wsel] <= io_wdata[2];
      if (ev_cmd)  cmd_reg     <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (!io_addr[AW-1])
      io_rdata = get_byte(is_cnt ? cur_c[sel_ch] : cur_a[sel_ch], ptr_q);
    else if (io_addr == PORT_STAT)
      io_rdata = BYTE_W'({req_q, tc_q});
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_data_acc,
  input logic              ev_clrff,
  input logic              ev_mreset,
  input logic              ev_clrall,
  input logic              ev_maskcmd,
  input logic [NUM_CH-1:0] ev_tc,
  input logic [NUM_CH-1:0] autoinit_v,
  input logic              ptr_q,
  input logic [NUM_CH-1:0] ch_mask,
  input logic [NUM_CH-1:0] tc_q,
  input logic [7:0]        cmd_reg
);
  p_ptr_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_acc && !ev_clrff && !ev_mreset |=> ptr_q != $past(ptr_q));

  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clrff |=> !ptr_q);

  p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clrall |=> ch_mask == '0);

  p_master_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mreset |=> (&ch_mask) && tc_q == '0 && cmd_reg == '0 && !ptr_q);

  p_tc_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_tc) && !ev_mreset |=> (tc_q & $past(ev_tc)) == $past(ev_tc));

  p_tc_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_tc & ~autoinit_v)) && !ev_maskcmd
      |=> (ch_mask & $past(ev_tc & ~autoinit_v)) == $past(ev_tc & ~autoinit_v));
endmodule

bind dma_regfile dma_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_data_acc (ev_data_acc),
  .ev_clrff    (ev_clrff),
  .ev_mreset   (ev_mreset),
  .ev_clrall   (ev_clrall),
  .ev_maskcmd  (ev_maskcmd),
  .ev_tc       (ev_tc),
  .autoinit_v  (autoinit_v),
  .ptr_q       (ptr_q),
  .ch_mask     (ch_mask),
  .tc_q        (tc_q),
  .cmd_reg     (cmd_reg)
);

// File: tb/dma_regfile_bench.sv
`timescale 1ns/1ps
module dma_regfile_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  io_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_rdata;
  logic        eng_upd = 0;
  logic [1:0]  eng_ch = 0;
  logic [15:0] eng_addr = 0, eng_cnt = 0;
  logic [3:0]  ch_mask;
  logic [23:0] ch_mode;
  logic [63:0] ch_addr, ch_cnt;
  logic [7:0]  cmd_reg;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_regfile u_dma_regfile (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .eng_upd(eng_upd),
    .eng_ch(eng_ch), .eng_addr(eng_addr), .eng_cnt(eng_cnt),
    .ch_mask(ch_mask), .ch_mode(ch_mode), .ch_addr(ch_addr),
    .ch_cnt(ch_cnt), .cmd_reg(cmd_reg)
  );

  // behavioural reference model
  int m_base_a[4], m_cur_a[4], m_base_c[4], m_cur_c[4], m_mode[4];
  int m_mask, m_ptr, m_tc, m_req, m_cmd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_base_a[i] = 0; m_cur_a[i] = 0; m_base_c[i] = 0; m_cur_c[i] = 0; m_mode[i] = 0;
      end
      m_mask = 15; m_ptr = 0; m_tc = 0; m_req = 0; m_cmd = 0;
    end else begin
      int tc_set, c, d;
      tc_set = 0;
      d = int'(io_wdata);
      if (eng_upd) begin
        c = int'(eng_ch);
        if (eng_cnt == 16'hFFFF) begin
          tc_set = 1 << c;
          if ((m_mode[c] & 4) != 0) begin
            m_cur_a[c] = m_base_a[c]; m_cur_c[c] = m_base_c[c];
          end else begin
            m_cur_a[c] = int'(eng_addr); m_cur_c[c] = int'(eng_cnt); m_mask |= 1 << c;
          end
        end else begin
          m_cur_a[c] = int'(eng_addr); m_cur_c[c] = int'(eng_cnt);
        end
      end
      if (io_rd && io_addr == 8) m_tc = 0;
      m_tc |= tc_set;
      if ((io_wr || io_rd) && io_addr < 8) begin
        if (io_wr) begin
          c = int'(io_addr) >> 1;
          if (io_addr[0]) begin
            m_base_c[c] = m_ptr ? ((m_base_c[c] & 255) | (d << 8)) : ((m_base_c[c] & 16'hFF00) | d);
            m_cur_c[c] = m_base_c[c];
          end else begin
            m_base_a[c] = m_ptr ? ((m_base_a[c] & 255) | (d << 8)) : ((m_base_a[c] & 16'hFF00) | d);
            m_cur_a[c] = m_base_a[c];
          end
        end
        m_ptr = 1 - m_ptr;
      end
      if (io_wr) begin
        c = d & 3;
        case (io_addr)
          8:  m_cmd = d;
          9:  m_req = ((d & 4) != 0) ? (m_req | (1 << c)) : (m_req & ~(1 << c));
          10: m_mask = ((d & 4) != 0) ? (m_mask | (1 << c)) : (m_mask & ~(1 << c));
          11: m_mode[c] = d >> 2;
          12: m_ptr = 0;
          13: begin m_mask = 15; m_ptr = 0; m_cmd = 0; m_tc = 0; m_req = 0; end
          14: m_mask = 0;
          15: m_mask = d & 15;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outputs compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 mask", int'(ch_mask), m_mask);
      chk("R11 cmd", int'(cmd_reg), m_cmd);
      for (int i = 0; i < 4; i++) begin
        chk("R6 mode", int'(ch_mode[6*i +: 6]), m_mode[i]);
        chk("R8 addr", int'(ch_addr[16*i +: 16]), m_cur_a[i]);
        chk("R8 cnt", int'(ch_cnt[16*i +: 16]), m_cur_c[i]);
      end
    end
  end

  function automatic int exp_rd(input int a);
    int v;
    if (a < 8) begin
      v = (a & 1) ? m_cur_c[a >> 1] : m_cur_a[a >> 1];
      return m_ptr ? ((v >> 8) & 255) : (v & 255);
    end
    if (a == 8) return (m_req << 4) | m_tc;
    return 0;
  endfunction

  task automatic wr(input int a, input int d);
    io_addr = 4'(a); io_wdata = 8'(d); io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input int a, input string req);
    io_addr = 4'(a); io_rd = 1; #1;
    chk(req, int'(io_rdata), exp_rd(a));
    @(negedge clk); io_rd = 0;
  endtask

  task automatic eng(input int c, input int a, input int n);
    eng_ch = 2'(c); eng_addr = 16'(a); eng_cnt = 16'(n); eng_upd = 1;
    @(negedge clk); eng_upd = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    chk("R7 reset mask", int'(ch_mask), 15);
    chk("R7 reset cmd", int'(cmd_reg), 0);
    rd(8, "R7 reset status");
    // R1 R3 address of channel 0, low then high
    wr(12, 0); wr(0, 8'h34); wr(0, 8'h12);
    chk("R3 addr ch0", int'(ch_addr[15:0]), 16'h1234);
    rd(0, "R1 low byte"); rd(0, "R1 high byte");
    chk("R1 low read", 0, 0);
    // R1 count of channel 2
    wr(5, 8'hFF); wr(5, 8'h00);
    chk("R1 cnt ch2", int'(ch_cnt[47:32]), 16'h00FF);
    // R2 pointer clear mid-sequence
    wr(3, 8'h11); wr(12, 8'hA5); wr(3, 8'h22);
    chk("R2 low byte after clear", int'(ch_cnt[23:16]) & 255, 8'h22);
    rd(3, "R2 read after clear");
    // R4 single mask
    wr(10, 8'h01);
    chk("R4 clear ch1", int'(ch_mask), 4'hD);
    wr(10, 8'h05);
    chk("R4 set ch1", int'(ch_mask), 4'hF);
    // R5 all masks
    wr(14, 8'hFF);
    chk("R5 clear all", int'(ch_mask), 0);
    wr(15, 8'h0A);
    chk("R5 write all", int'(ch_mask), 4'hA);
    // R6 modes: ch0 autoinit, ch3 without
    wr(11, 8'h58); wr(11, 8'h47);
    chk("R6 mode ch0", int'(ch_mode[5:0]), 8'h58 >> 2);
    chk("R6 mode ch3", int'(ch_mode[23:18]), 8'h47 >> 2);
    // R8 plain engine update
    eng(0, 16'h1300, 16'h0042);
    chk("R8 eng addr", int'(ch_addr[15:0]), 16'h1300);
    // R10 autoinit reload on ch0, mask on ch3
    wr(1, 8'h10); wr(1, 8'h00);
    eng(0, 16'h2000, 16'hFFFF);
    chk("R10 reload addr", int'(ch_addr[15:0]), 16'h1234);
    chk("R10 reload cnt", int'(ch_cnt[15:0]), 16'h0010);
    wr(10, 8'h03);
    eng(3, 16'h0777, 16'hFFFF);
    chk("R10 mask on tc", int'(ch_mask[3]), 1);
    // R9 status flags, cleared by read
    rd(8, "R9 status tc");
    rd(8, "R9 status cleared");
    // R11 command and request
    wr(8, 8'h20); wr(9, 8'h06);
    chk("R11 cmd", int'(cmd_reg), 8'h20);
    rd(8, "R11 request bit");
    rd(6, "R11 low read"); rd(13, "R11 other port zero");
    // R7 master reset by port
    wr(14, 0); wr(0, 8'h55); wr(13, 8'h99);
    chk("R7 mreset mask", int'(ch_mask), 15);
    chk("R7 mreset cmd", int'(cmd_reg), 0);
    rd(8, "R7 mreset status");
    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      int op;
      op = int'($urandom_range(0, 9));
      eng_upd = ($urandom_range(0, 3) == 0);
      eng_ch = 2'($urandom_range(0, 3));
      eng_addr = 16'($urandom);
      eng_cnt = ($urandom_range(0, 2) == 0) ? 16'hFFFF : 16'($urandom);
      io_addr = 4'($urandom_range(0, 15));
      io_wdata = 8'($urandom);
      if (op < 4) begin
        io_wr = 1;
      end else if (op < 8) begin
        io_rd = 1; #1;
        chk("R9 random read", int'(io_rdata), exp_rd(int'(io_addr)));
      end
      @(negedge clk);
      io_wr = 0; io_rd = 0; eng_upd = 0;
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule